// File: doc/BRIEF.md
# Two-Register I2C Control Slave with Blanking-Aligned Level Updates

This block is a write-only I2C slave that holds two 8-bit control registers for a video output path: a mode register and a control register. A host addresses the slave, sends a subaddress byte that selects the register, and then sends one or more data bytes. Most bits of either register change as soon as the byte is acknowledged. The bits that set picture levels work differently: the black-level bit of the mode register and the two overlay-level bits of the control register are first stored in a shadow copy. They reach the outputs only when vertical blanking begins, so a level never changes partway through a picture.

SCL and SDA are sampled in the system clock domain through two-stage synchronizers, and bus edges are found by comparing successive samples. The slave pulls SDA low through an open-drain enable output. It does not support reads and does not stretch the clock.

Top module: `vid_ctrl_i2c_regs`

## Requirements
- R1: After reset, `mode_o` and `ctrl_o` equal their reset parameters (0x00 by default), and `sda_oe_o` is 0.
- R2: A byte that follows a start condition and equals {DEV_ADDR, 0} (7-bit address in bits 7:1, write bit 0 in bit 0) is acknowledged: `sda_oe_o` is 1 while SCL is high on the ninth clock. Any other 7-bit address gets no acknowledge.
- R3: When the address does not match, or bit 0 of the address byte is 1 (read), no acknowledge is given. Every following byte is then ignored until the next start condition: there is no acknowledge and no register change.
- R4: Bytes are received MSB first. Subaddress 0 selects the mode register. A data byte written to it updates `mode_o` bits 7:2 and bit 0 when the acknowledge is driven.
- R5: Subaddress 1 selects the control register. A data byte written to it updates `ctrl_o` bits 7:2 when the acknowledge is driven.
- R6: `mode_o` bit 1 (black level) takes its last written value only on the first clock after `vblank_i` goes from 0 to 1. At all other times it holds.
- R7: `ctrl_o` bits 1:0 (overlay level) take their last written value only on the first clock after `vblank_i` goes from 0 to 1. At all other times they hold.
- R8: A level bit written while `vblank_i` is already 1 is not applied in that blanking period. It is applied at the next 0-to-1 transition of `vblank_i`.
- R9: Consecutive data bytes in one transaction go to consecutive subaddresses. A subaddress above 1, whether sent directly or reached by auto-increment, is not acknowledged, is not stored, and causes the rest of the transaction to be ignored.
- R10: A repeated start begins a new address phase. After a stop condition, bytes clocked without a new start are neither acknowledged nor stored.
- R11: The slave drives the acknowledge only while SCL is low, and releases SDA at the falling edge of the ninth SCL clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | When 1, the slave pulls SDA low |
| vblank_i | input | 1 | Vertical blanking indicator, active high, synchronous to clk |
| mode_o | output | 8 | Active mode register; bit 1 is the black-level bit |
| ctrl_o | output | 8 | Active control register; bits 1:0 are the overlay level |

## Verification
Every one of the 128 seven-bit addresses is sent with the write bit clear, and a read-bit variant is also sent. Together these show that only the configured address is acknowledged and that the address is decoded MSB first. Thirty-two arithmetically spread data pairs are then written to both registers in single transactions, and the outputs are compared before and after a blanking pulse. This separates the bits that must change at once from the level bits that must wait. Further sequences cover a write made while blanking is already active, a mismatched address followed by data, auto-increment past the last register, an out-of-range subaddress, a repeated start, and bytes clocked after a stop. Each sequence shows whether the slave ignores bus activity it should ignore.

// File: rtl/vid_ctrl_i2c_regs.sv
module vid_ctrl_i2c_regs #(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter logic [7:0] MR_DEFER = 8'h02,
  parameter logic [7:0] CR_DEFER = 8'h03,
  parameter logic [7:0] MR_INIT  = 8'h00,
  parameter logic [7:0] CR_INIT  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic       vblank_i,
  output logic [7:0] mode_o,
  output logic [7:0] ctrl_o
);

  localparam logic [7:0] ADDR_BYTE = {DEV_ADDR, 1'b0};
  localparam logic [7:0] LAST_SUB  = 8'd1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SUB, S_DATA, S_IGN} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic       vb_d;
  st_t        st;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, sub_q;
  logic [7:0] mr_q, cr_q, mr_sh, cr_sh, mr_n, cr_n;

  wire scl_c    = scl_sy[1];
  wire sda_c    = sda_sy[1];
  wire scl_rise = scl_c & ~scl_d;
  wire scl_fall = ~scl_c & scl_d;
  wire start_c  = scl_c & scl_d & sda_d & ~sda_c;
  wire stop_c   = scl_c & scl_d & ~sda_d & sda_c;
  wire active   = (st != S_IDLE) && (st != S_IGN);
  wire byte_end = active && scl_fall && (bit_cnt == 4'd8);
  wire ack_end  = active && scl_fall && (bit_cnt == 4'd9);
  wire wr_mr    = byte_end && (st == S_DATA) && (sub_q == 8'd0);
  wire wr_cr    = byte_end && (st == S_DATA) && (sub_q == LAST_SUB);
  wire vb_rise  = vblank_i & ~vb_d;

  assign mode_o = mr_q;
  assign ctrl_o = cr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
      vb_d   <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_c;
      sda_d  <= sda_c;
      vb_d   <= vblank_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bit_cnt  <= 4'd0;
      shreg    <= 8'd0;
      sub_q    <= 8'd0;
      sda_oe_o <= 1'b0;
    end else if (start_c) begin
      st       <= S_ADDR;
      bit_cnt  <= 4'd0;
      sda_oe_o <= 1'b0;
    end else if (stop_c) begin
      st       <= S_IDLE;
      bit_cnt  <= 4'd0;
      sda_oe_o <= 1'b0;
    end else if (active) begin
      if (scl_rise && bit_cnt < 4'd9) begin
        if (bit_cnt < 4'd8) shreg <= {shreg[6:0], sda_c};
        bit_cnt <= bit_cnt + 4'd1;
      end else if (byte_end) begin
        case (st)
          S_ADDR:
            if (shreg == ADDR_BYTE) begin
              sda_oe_o <= 1'b1;
              st       <= S_SUB;
            end else st <= S_IGN;
          S_SUB:
            if (shreg <= LAST_SUB) begin
              sda_oe_o <= 1'b1;
              sub_q    <= shreg;
              st       <= S_DATA;
            end else st <= S_IGN;
          S_DATA:
            if (sub_q <= LAST_SUB) begin
              sda_oe_o <= 1'b1;
              sub_q    <= sub_q + 8'd1;
            end else st <= S_IGN;
          default: st <= S_IGN;
        endcase
      end else if (ack_end) begin
        sda_oe_o <= 1'b0;
        bit_cnt  <= 4'd0;
      end
    end
  end

  always_comb begin
    mr_n = mr_q;
    cr_n = cr_q;
    if (vb_rise) begin
      mr_n = (mr_q & ~MR_DEFER) | (mr_sh & MR_DEFER);
      cr_n = (cr_q & ~CR_DEFER) | (cr_sh & CR_DEFER);
    end
    if (wr_mr) mr_n = (mr_n & MR_DEFER) | (shreg & ~MR_DEFER);
    if (wr_cr) cr_n = (cr_n & CR_DEFER) | (shreg & ~CR_DEFER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q  <= MR_INIT;
      cr_q  <= CR_INIT;
      mr_sh <= MR_INIT;
      cr_sh <= CR_INIT;
    end else begin
      mr_q <= mr_n;
      cr_q <= cr_n;
      if (wr_mr) mr_sh <= shreg;
      if (wr_cr) cr_sh <= shreg;
    end
  end

  AST_ACK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe_o |-> (bit_cnt == 4'd8 || bit_cnt == 4'd9)); // R2
  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !scl_c); // R11
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o && scl_fall && bit_cnt == 4'd9) |=> !sda_oe_o); // R11
  AST_IGN_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_oe_o); // R3
  AST_IGN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN || st == S_IDLE) |=> ($stable(mode_o & ~MR_DEFER) && $stable(ctrl_o & ~CR_DEFER))); // R3
  AST_MR_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank_i && !vb_d) |=> $stable(mode_o & MR_DEFER)); // R6
  AST_CR_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(vblank_i && !vb_d) |=> $stable(ctrl_o & CR_DEFER)); // R7

endmodule

// File: tb/test_vid_ctrl_i2c_regs.sv
module test_vid_ctrl_i2c_regs;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam logic [7:0] MRD  = 8'h02;
  localparam logic [7:0] CRD  = 8'h03;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_host = 1'b1, vblank = 1'b0;
  logic sda_oe;
  logic [7:0] mode, ctrl;
  wire sda_line = sda_host & ~sda_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_mr = 8'h00, exp_cr = 8'h00, sh_mr = 8'h00, sh_cr = 8'h00;

  always #4 clk = ~clk;

  vid_ctrl_i2c_regs #(.DEV_ADDR(ADDR)) i_vid_ctrl_i2c_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .vblank_i(vblank), .mode_o(mode), .ctrl_o(ctrl));

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_wr(input logic [7:0] sub, input logic [7:0] v);
    if (sub == 8'd0) begin sh_mr = v; exp_mr = (exp_mr & MRD) | (v & ~MRD); end
    if (sub == 8'd1) begin sh_cr = v; exp_cr = (exp_cr & CRD) | (v & ~CRD); end
  endtask

  task automatic model_vb();
    exp_mr = (exp_mr & ~MRD) | (sh_mr & MRD);
    exp_cr = (exp_cr & ~CRD) | (sh_cr & CRD);
  endtask

  task automatic i2c_start();
    sda_host = 1'b1; wclk(4);
    scl = 1'b1; wclk(HP);
    sda_host = 1'b0; wclk(HP);
    scl = 1'b0; wclk(4);
  endtask

  task automatic i2c_stop();
    sda_host = 1'b0; wclk(HP);
    scl = 1'b1; wclk(HP);
    sda_host = 1'b1; wclk(HP);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic rel);
    for (int i = 7; i >= 0; i--) begin
      scl = 1'b0; wclk(4);
      sda_host = b[i]; wclk(HP);
      scl = 1'b1; wclk(HP);
    end
    scl = 1'b0; wclk(4);
    sda_host = 1'b1; wclk(HP);
    scl = 1'b1; wclk(HP);
    ack = sda_oe;
    scl = 1'b0; wclk(6);
    rel = ~sda_oe;
  endtask

  task automatic pulse_vb();
    vblank = 1'b1; wclk(4);
    model_vb();
    vblank = 1'b0; wclk(2);
  endtask

  initial begin
    logic a, r;
    logic [7:0] v, c;
    wclk(5);
    rst_n = 1'b1;
    wclk(3);
    check("R1 mode reset", mode, 8'h00);
    check("R1 ctrl reset", ctrl, 8'h00);
    check("R1 sda_oe reset", {7'd0, sda_oe}, 8'h00);

    for (int k = 0; k < 128; k++) begin
      i2c_start();
      send_byte({k[6:0], 1'b0}, a, r);
      check("R2 address sweep ack", {7'd0, a}, {7'd0, k[6:0] == ADDR});
      if (k[6:0] == ADDR) check("R11 ack released", {7'd0, r}, 8'h01);
      i2c_stop();
    end

    for (int k = 0; k < 32; k++) begin
      v = 8'(k * 37 + 5);
      c = v ^ 8'hA5;
      i2c_start();
      send_byte({ADDR, 1'b0}, a, r);
      check("R2 addr ack", {7'd0, a}, 8'h01);
      send_byte(8'd0, a, r);
      check("R4 sub ack", {7'd0, a}, 8'h01);
      send_byte(v, a, r);
      model_wr(8'd0, v);
      check("R4 mode immediate bits", mode, exp_mr);
      send_byte(c, a, r);
      model_wr(8'd1, c);
      check("R5 ctrl immediate bits", ctrl, exp_cr);
      check("R11 release after data", {7'd0, r}, 8'h01);
      i2c_stop();
      check("R6 black level held", mode, exp_mr);
      check("R7 overlay level held", ctrl, exp_cr);
      pulse_vb();
      check("R6 black level applied", mode, exp_mr);
      check("R7 overlay level applied", ctrl, exp_cr);
    end

    vblank = 1'b1; wclk(3); model_vb(); wclk(2);
    v = exp_mr ^ 8'h03;
    c = exp_cr ^ 8'h03;
    i2c_start();
    send_byte({ADDR, 1'b0}, a, r);
    send_byte(8'd0, a, r);
    send_byte(v, a, r); model_wr(8'd0, v);
    send_byte(c, a, r); model_wr(8'd1, c);
    i2c_stop();
    check("R8 mode during blanking", mode, exp_mr);
    check("R8 ctrl during blanking", ctrl, exp_cr);
    vblank = 1'b0; wclk(4);
    check("R8 mode after blanking ends", mode, exp_mr);
    vblank = 1'b1; wclk(3); model_vb();
    check("R8 mode next blanking", mode, exp_mr);
    check("R8 ctrl next blanking", ctrl, exp_cr);
    vblank = 1'b0; wclk(2);

    i2c_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, a, r);
    check("R3 wrong addr nack", {7'd0, a}, 8'h00);
    send_byte(8'd0, a, r);
    check("R3 ignored sub nack", {7'd0, a}, 8'h00);
    send_byte(~exp_mr, a, r);
    check("R3 ignored data nack", {7'd0, a}, 8'h00);
    i2c_stop();
    pulse_vb();
    check("R3 mode untouched", mode, exp_mr);
    i2c_start();
    send_byte({ADDR, 1'b1}, a, r);
    check("R3 read bit nack", {7'd0, a}, 8'h00);
    send_byte(8'd1, a, r);
    send_byte(~exp_cr, a, r);
    i2c_stop();
    pulse_vb();
    check("R3 ctrl untouched", ctrl, exp_cr);

    i2c_start();
    send_byte({ADDR, 1'b0}, a, r);
    send_byte(8'd1, a, r);
    send_byte(8'h6A, a, r); model_wr(8'd1, 8'h6A);
    check("R9 ctrl ack", {7'd0, a}, 8'h01);
    send_byte(8'h95, a, r);
    check("R9 past last nack", {7'd0, a}, 8'h00);
    send_byte(8'h33, a, r);
    check("R9 ignored after nack", {7'd0, a}, 8'h00);
    i2c_stop();
    pulse_vb();
    check("R9 ctrl keeps first byte", ctrl, exp_cr);
    check("R9 mode untouched", mode, exp_mr);
    i2c_start();
    send_byte({ADDR, 1'b0}, a, r);
    send_byte(8'd5, a, r);
    check("R9 bad sub nack", {7'd0, a}, 8'h00);
    send_byte(8'hFF, a, r);
    i2c_stop();
    pulse_vb();
    check("R9 bad sub no write", mode, exp_mr);

    i2c_start();
    send_byte({ADDR, 1'b0}, a, r);
    send_byte(8'd0, a, r);
    i2c_start();
    send_byte({ADDR, 1'b0}, a, r);
    check("R10 repeated start addr ack", {7'd0, a}, 8'h01);
    send_byte(8'd1, a, r);
    send_byte(8'h5C, a, r); model_wr(8'd1, 8'h5C);
    i2c_stop();
    check("R10 ctrl after repeated start", ctrl, exp_cr);
    check("R10 mode untouched", mode, exp_mr);
    send_byte({ADDR, 1'b0}, a, r);
    check("R10 no ack after stop", {7'd0, a}, 8'h00);
    send_byte(8'd0, a, r);
    send_byte(~exp_mr, a, r);
    i2c_stop();
    pulse_vb();
    check("R10 no write after stop", mode, exp_mr);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule